// File: doc/BRIEF.md
# Interrupt Controller with Split Priority Drop and Deactivation

This block collects a small set of interrupt lines, tracks a four-state life cycle for each one, and presents a single interrupt request to one processor. Every line is configured as level-sensitive or edge-triggered and carries a programmable 4-bit priority, where a lower value is more urgent. The processor side uses three strobes: acknowledge, end-of-interrupt and deactivate. Acknowledge returns the ID of the most urgent eligible line and raises the running priority. End-of-interrupt lowers the running priority.

The block treats two operations as separate. Lowering the running priority, called priority drop, only changes the preemption threshold. Deactivation only changes the state of one line. A mode input selects how the two are issued. With `split_mode` low, one end-of-interrupt strobe drops the priority and also deactivates the line named by `eoi_id`. With `split_mode` high, end-of-interrupt only drops the priority, and the line stays active until a deactivate strobe names it. A handler can therefore let lower-priority work preempt it again while its own source stays blocked.

Each line is held in one of four states: `LS_IDLE` (inactive), `LS_PEND` (pending), `LS_ACT` (active) and `LS_ACTPEND` (active and pending). The named transitions are:
- raise: `LS_IDLE` to `LS_PEND`.
- withdraw: `LS_PEND` to `LS_IDLE`, level lines only.
- take: `LS_PEND` to `LS_ACT` or `LS_ACTPEND`.
- re-raise: `LS_ACT` to `LS_ACTPEND`.
- drop-source: `LS_ACTPEND` to `LS_ACT`.
- retire: `LS_ACTPEND` to `LS_PEND`, or `LS_ACT` to `LS_IDLE`.

The running priorities are kept on a stack of four entries.

Top module: `intc_split_eoi`

## Requirements
- R1: After reset every line is in `LS_IDLE`, so `line_pending` and `line_active` are 0. `cpu_irq` is 0, `running_prio` is 15 (the idle priority) and `ack_id` is 15. Bit i of `line_pending` is set in `LS_PEND` and `LS_ACTPEND`. Bit i of `line_active` is set in `LS_ACT` and `LS_ACTPEND`.
- R2: A level line whose input is sampled high in `LS_IDLE` enters `LS_PEND` one cycle later. If the input is sampled low while the line is in `LS_PEND`, the line returns to `LS_IDLE`.
- R3: Acknowledging a level line whose input is still high moves it to `LS_ACTPEND`. A later deassertion of the input moves it to `LS_ACT`. The active bit of a line is set only by an acknowledge.
- R4: Deactivation clears only the active part of a state. `LS_ACTPEND` goes to `LS_PEND` and `LS_ACT` goes to `LS_IDLE`. A line that is not active ignores deactivation.
- R5: A line never goes from `LS_ACTPEND` to `LS_IDLE` in one cycle. If a level input falls in the same cycle as a deactivation, the line spends one cycle in `LS_ACT` and then enters `LS_IDLE`.
- R6: An edge line latches `LS_PEND` on a rising edge of its input. Acknowledging the line clears the pending part, even if the input is still high. A new rising edge while the line is in `LS_ACT` moves it to `LS_ACTPEND`.
- R7: With `split_mode` high, end-of-interrupt pops the running priority and leaves every line state unchanged. A deactivate strobe then retires the line named by `dir_id`.
- R8: With `split_mode` low, end-of-interrupt pops the running priority and deactivates the line named by `eoi_id`. In this mode the deactivate strobe has no effect.
- R9: `cpu_irq` is high exactly when some line is in `LS_PEND` and its priority value is strictly lower than `running_prio`. This requires that the stack is not full.
- R10: Acknowledge grants the eligible line with the lowest priority value. Among equal priorities the lowest index wins. The grant places the line's ID on `ack_id` and its priority on `running_prio` from the next cycle.
- R11: An acknowledge while nothing is eligible returns the spurious ID 15 (all ones). It changes no line state and does not change `running_prio`.
- R12: The priority stack holds 4 entries. While it is full, no line is signalled, and acknowledge returns the spurious ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt input lines |
| cfg_edge | input | 8 | Per line: 1 selects edge-triggered, 0 selects level-sensitive |
| cfg_prio | input | 32 | Per-line 4-bit priority; line i uses bits [4i+3:4i] |
| split_mode | input | 1 | 1 selects separate priority drop and deactivation |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 4 | Line named by end-of-interrupt |
| dir_req | input | 1 | Deactivate strobe |
| dir_id | input | 4 | Line named by deactivate |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_id | output | 4 | ID returned by the last acknowledge (15 means spurious) |
| running_prio | output | 4 | Current running priority (15 when idle) |
| line_pending | output | 8 | Pending part of each line's state |
| line_active | output | 8 | Active part of each line's state |

## Verification
The assertions assume the processor acknowledges only after reset is released, and never issues end-of-interrupt on an empty stack. They also assume at most one of acknowledge and end-of-interrupt is active in any cycle. The stimulus follows these rules by raising only one strobe per cycle and pairing each end-of-interrupt with an earlier acknowledge. It also changes inputs only at the falling clock edge, so each input change reaches the line state machines at exactly one rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Four-state life cycle of one interrupt line.
    // Bit 0 is the pending part and bit 1 is the active part.
    typedef enum logic [1:0] {
        LS_IDLE    = 2'b00,
        LS_PEND    = 2'b01,
        LS_ACT     = 2'b10,
        LS_ACTPEND = 2'b11
    } line_state_t;

endpackage

// File: rtl/intc_line.sv
module intc_line
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic edge_mode,
    input  logic take,
    input  logic retire,
    output logic pending_o,
    output logic active_o
);

    line_state_t state_q, state_d;
    logic        irq_q;
    logic        defer_q, defer_d;
    logic        rise;
    logic        retire_eff;

    assign rise       = irq_in & ~irq_q;
    assign retire_eff = retire | defer_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            irq_q   <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_in;
            defer_q <= defer_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        defer_d = 1'b0;
        if (!edge_mode) begin
            unique case (state_q)
                LS_IDLE: begin
                    if (irq_in) state_d = LS_PEND;                 // raise
                end
                LS_PEND: begin
                    if (take)         state_d = irq_in ? LS_ACTPEND : LS_ACT; // take
                    else if (!irq_in) state_d = LS_IDLE;           // withdraw
                end
                LS_ACT: begin
                    if (retire_eff)  state_d = irq_in ? LS_PEND : LS_IDLE;   // retire
                    else if (irq_in) state_d = LS_ACTPEND;         // re-raise
                end
                LS_ACTPEND: begin
                    if (!irq_in) begin
                        state_d = LS_ACT;                          // drop-source first
                        defer_d = retire_eff;                      // retire next cycle
                    end else if (retire_eff) begin
                        state_d = LS_PEND;                         // retire
                    end
                end
                default: state_d = LS_IDLE;
            endcase
        end else begin
            unique case (state_q)
                LS_IDLE: begin
                    if (rise) state_d = LS_PEND;                   // raise
                end
                LS_PEND: begin
                    if (take) state_d = rise ? LS_ACTPEND : LS_ACT; // take
                end
                LS_ACT: begin
                    if (rise && retire_eff) state_d = LS_PEND;
                    else if (rise)          state_d = LS_ACTPEND;  // re-raise
                    else if (retire_eff)    state_d = LS_IDLE;     // retire
                end
                LS_ACTPEND: begin
                    if (retire_eff) state_d = LS_PEND;             // retire
                end
                default: state_d = LS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pending_o = state_q[0];
        active_o  = state_q[1];
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N_LINES = 8,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = 4
) (
    input  logic [N_LINES-1:0]        cand,
    input  logic [N_LINES*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         threshold,
    input  logic                      blocked,
    output logic                      any_elig,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);

    always_comb begin
        any_elig = 1'b0;
        win_id   = '1;
        win_prio = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (cand[i] && !blocked &&
                (prio[i*PRIO_W +: PRIO_W] < threshold) &&
                (!any_elig || (prio[i*PRIO_W +: PRIO_W] < win_prio))) begin
                any_elig = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_d;
    logic [PRIO_W-1:0] slot_q [DEPTH];

    always_comb begin
        cnt_mid = cnt_q;
        if (pop && cnt_q != '0) cnt_mid = cnt_q - 1'b1;
        cnt_d = cnt_mid;
        if (push && cnt_mid != CNT_W'(DEPTH)) cnt_d = cnt_mid + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '1;
            else if (push && cnt_mid == CNT_W'(g))
                slot_q[g] <= push_prio;
        end
    end

    always_comb begin
        top_prio = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) top_prio = slot_q[i];
        end
        full = (cnt_q == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/intc_split_eoi.sv
module intc_split_eoi #(
    parameter int N_LINES     = 8,
    parameter int PRIO_W      = 4,
    parameter int STACK_DEPTH = 4,
    parameter int ID_W        = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_in,
    input  logic [N_LINES-1:0]        cfg_edge,
    input  logic [N_LINES*PRIO_W-1:0] cfg_prio,
    input  logic                      split_mode,
    input  logic                      ack_req,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    input  logic                      dir_req,
    input  logic [ID_W-1:0]           dir_id,
    output logic                      cpu_irq,
    output logic [ID_W-1:0]           ack_id,
    output logic [PRIO_W-1:0]         running_prio,
    output logic [N_LINES-1:0]        line_pending,
    output logic [N_LINES-1:0]        line_active
);

    localparam logic [ID_W-1:0] SPURIOUS = '1;

    logic [N_LINES-1:0] cand;
    logic [N_LINES-1:0] take_v;
    logic [N_LINES-1:0] retire_v;
    logic               any_elig;
    logic [ID_W-1:0]    win_id;
    logic [PRIO_W-1:0]  win_prio;
    logic               grant;
    logic               stk_full;

    assign grant = ack_req & any_elig;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign take_v[i]   = grant && (win_id == ID_W'(i));
        assign retire_v[i] = (split_mode  && dir_req && (dir_id == ID_W'(i))) ||
                             (!split_mode && eoi_req && (eoi_id == ID_W'(i)));
        assign cand[i]     = line_pending[i] & ~line_active[i];

        intc_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_in    (irq_in[i]),
            .edge_mode (cfg_edge[i]),
            .take      (take_v[i]),
            .retire    (retire_v[i]),
            .pending_o (line_pending[i]),
            .active_o  (line_active[i])
        );
    end

    intc_arbiter #(
        .N_LINES (N_LINES),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .cand      (cand),
        .prio      (cfg_prio),
        .threshold (running_prio),
        .blocked   (stk_full),
        .any_elig  (any_elig),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    intc_prio_stack #(
        .DEPTH  (STACK_DEPTH),
        .PRIO_W (PRIO_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant),
        .push_prio (win_prio),
        .pop       (eoi_req),
        .top_prio  (running_prio),
        .full      (stk_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ack_id <= SPURIOUS;
        else if (ack_req) ack_id <= grant ? win_id : SPURIOUS;
    end

    assign cpu_irq = any_elig;

endmodule

// File: rtl/intc_split_eoi_chk.sv
module intc_split_eoi_chk #(
    parameter int N_LINES = 8,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_req,
    input logic               eoi_req,
    input logic               cpu_irq,
    input logic [ID_W-1:0]    ack_id,
    input logic [PRIO_W-1:0]  running_prio,
    input logic [N_LINES-1:0] line_pending,
    input logic [N_LINES-1:0] line_active,
    input logic               stk_full
);

    // R5: active-and-pending never reaches inactive in one cycle
    p_no_direct_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_pending & line_active) != '0) |=>
        (($past(line_pending & line_active) & ~(line_pending | line_active)) == '0));

    // R3: an active bit only appears after an acknowledge
    p_active_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_active & ~$past(line_active)) != '0) |-> $past(ack_req));

    // R9: a request always has a pending, non-active line behind it
    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((line_pending & ~line_active) != '0));

    // R11: acknowledge with nothing eligible returns all ones
    p_spurious_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !cpu_irq) |=> (ack_id == '1));

    // R10: a granted acknowledge raises the running priority
    p_ack_raises_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && cpu_irq && !eoi_req) |=> (running_prio < $past(running_prio)));

    // R12: a full stack silences the request
    p_full_stack_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !cpu_irq);

endmodule

bind intc_split_eoi intc_split_eoi_chk #(
    .N_LINES (N_LINES),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_req      (ack_req),
    .eoi_req      (eoi_req),
    .cpu_irq      (cpu_irq),
    .ack_id       (ack_id),
    .running_prio (running_prio),
    .line_pending (line_pending),
    .line_active  (line_active),
    .stk_full     (stk_full)
);

// File: tb/intc_split_eoi_test.sv
`timescale 1ns/1ps
module intc_split_eoi_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  irq_in;
    logic [7:0]  cfg_edge;
    logic [31:0] cfg_prio;
    logic        split_mode, ack_req, eoi_req, dir_req;
    logic [3:0]  eoi_id, dir_id;
    logic        cpu_irq;
    logic [3:0]  ack_id, running_prio;
    logic [7:0]  line_pending, line_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    intc_split_eoi uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
        .cfg_prio(cfg_prio), .split_mode(split_mode), .ack_req(ack_req),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .dir_req(dir_req), .dir_id(dir_id),
        .cpu_irq(cpu_irq), .ack_id(ack_id), .running_prio(running_prio),
        .line_pending(line_pending), .line_active(line_active)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; cfg_edge = '0; cfg_prio = '1;
        split_mode = 1'b0; ack_req = 0; eoi_req = 0; dir_req = 0;
        eoi_id = '0; dir_id = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_prio(input int line, input int p);
        cfg_prio[line*4 +: 4] = 4'(p);
    endtask

    task automatic do_ack();
        ack_req = 1; tick(); ack_req = 0;
    endtask

    task automatic do_eoi(input int id);
        eoi_req = 1; eoi_id = 4'(id); tick(); eoi_req = 0;
    endtask

    task automatic do_dir(input int id);
        dir_req = 1; dir_id = 4'(id); tick(); dir_req = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "pending", line_pending, 0);
        chk("R1", "active", line_active, 0);
        chk("R1", "cpu_irq", cpu_irq, 0);
        chk("R1", "running_prio", running_prio, 15);
        chk("R1", "ack_id", ack_id, 15);
    endtask

    task automatic t_level_basic();
        do_reset(); set_prio(2, 5);
        irq_in[2] = 1; tick();
        chk("R2", "raise pending", line_pending, 8'h04);
        chk("R9", "irq raised", cpu_irq, 1);
        irq_in[2] = 0; tick();
        chk("R2", "withdraw pending", line_pending, 0);
        chk("R9", "irq dropped", cpu_irq, 0);
    endtask

    task automatic t_split_level();
        do_reset(); set_prio(2, 5); split_mode = 1;
        irq_in[2] = 1; tick();
        do_ack();
        chk("R10", "ack_id", ack_id, 2);
        chk("R10", "running_prio", running_prio, 5);
        chk("R3", "AP pending", line_pending, 8'h04);
        chk("R3", "AP active", line_active, 8'h04);
        do_eoi(2);
        chk("R7", "prio popped", running_prio, 15);
        chk("R7", "state kept pending", line_pending, 8'h04);
        chk("R7", "state kept active", line_active, 8'h04);
        irq_in[2] = 0; tick();
        chk("R3", "drop-source pending", line_pending, 0);
        chk("R3", "drop-source active", line_active, 8'h04);
        do_dir(2);
        chk("R4", "retire to idle", line_active, 0);
        // AP -> pending through deactivate
        irq_in[2] = 1; tick();
        do_ack();
        do_dir(2);
        chk("R4", "AP retire pending", line_pending, 8'h04);
        chk("R4", "AP retire active", line_active, 0);
        chk("R9", "blocked by threshold", cpu_irq, 0);
        do_eoi(2);
        chk("R9", "signalled after drop", cpu_irq, 1);
        irq_in[2] = 0; tick();
        chk("R2", "idle again", line_pending, 0);
    endtask

    task automatic t_same_cycle();
        do_reset(); set_prio(2, 5); split_mode = 1;
        irq_in[2] = 1; tick();
        do_ack();
        irq_in[2] = 0; do_dir(2);
        chk("R5", "step1 active", line_active, 8'h04);
        chk("R5", "step1 pending", line_pending, 0);
        tick();
        chk("R5", "step2 active", line_active, 0);
        chk("R5", "step2 pending", line_pending, 0);
    endtask

    task automatic t_edge_nonsplit();
        do_reset(); cfg_edge[4] = 1; set_prio(4, 3); split_mode = 0;
        irq_in[4] = 1; tick();
        chk("R6", "edge latched", line_pending, 8'h10);
        tick();
        chk("R6", "held high no change", line_pending, 8'h10);
        do_ack();
        chk("R6", "ack clears pending", line_pending, 0);
        chk("R6", "ack sets active", line_active, 8'h10);
        chk("R10", "edge ack_id", ack_id, 4);
        irq_in[4] = 0; tick();
        irq_in[4] = 1; tick();
        chk("R6", "re-raise pending", line_pending, 8'h10);
        chk("R6", "re-raise active", line_active, 8'h10);
        do_eoi(4);
        chk("R8", "eoi deactivates", line_active, 0);
        chk("R8", "pending kept", line_pending, 8'h10);
        chk("R8", "prio popped", running_prio, 15);
        do_ack();
        do_dir(4);
        chk("R8", "dir ignored", line_active, 8'h10);
        do_eoi(4);
        chk("R8", "eoi retires", line_active, 0);
    endtask

    task automatic t_priority();
        do_reset(); split_mode = 0;
        set_prio(1, 6); set_prio(5, 6); set_prio(6, 2);
        irq_in[1] = 1; irq_in[5] = 1; tick();
        do_ack();
        chk("R10", "tie lowest index", ack_id, 1);
        chk("R9", "equal prio blocked", cpu_irq, 0);
        irq_in[6] = 1; tick();
        chk("R9", "preempt signalled", cpu_irq, 1);
        do_ack();
        chk("R10", "preempt ack_id", ack_id, 6);
        chk("R10", "nested prio", running_prio, 2);
        do_ack();
        chk("R11", "spurious id", ack_id, 15);
        chk("R11", "prio unchanged", running_prio, 2);
        chk("R11", "pending unchanged", line_pending, 8'h62);
    endtask

    task automatic t_stack_full();
        do_reset(); split_mode = 0;
        set_prio(0, 10); set_prio(1, 8); set_prio(2, 6); set_prio(3, 4); set_prio(7, 1);
        for (int k = 0; k < 4; k++) begin
            irq_in[k] = 1; tick();
            do_ack();
        end
        chk("R12", "depth4 prio", running_prio, 4);
        irq_in[7] = 1; tick();
        chk("R12", "full no irq", cpu_irq, 0);
        do_ack();
        chk("R12", "full ack spurious", ack_id, 15);
        do_eoi(3);
        chk("R12", "pop prio", running_prio, 6);
        chk("R12", "irq after pop", cpu_irq, 1);
        chk("R8", "line3 back to pending", line_active[3], 0);
    endtask

    initial begin
        t_reset();
        t_level_basic();
        t_split_level();
        t_same_cycle();
        t_edge_nonsplit();
        t_priority();
        t_stack_full();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule